// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Registers

This block keeps the time of day and the calendar as packed BCD counters: seconds, minutes, hours in 24-hour form, day of week, date of month, month and a two-digit year. An enable strobe at the 32,768 Hz timebase rate is divided down so that the counters move forward once per second. The month length and leap-year correction happen automatically.

The host never reaches the live counters. It sees eight byte-wide shadow registers at the eight highest addresses of a byte-addressed map. The counters copy their value into these shadows once per second. A control byte sits at the lowest of those eight addresses. Its two top bits decide when the counters and the shadows exchange data. One bit freezes the shadows so the host can read a consistent snapshot. The other bit stops the clock while the host writes a new time, and loads that time when the bit is cleared. The remaining six control bits hold a calibration setting. The block stores this setting and reports it back, but does not act on it.

Top module: `rtc_calendar_top`

## Requirements
- R1: The time advances by exactly one second for every TICKS_PER_SEC clock cycles in which tick_en is high. Cycles with tick_en low do not count.
- R2: Seconds and minutes count 00 to 59 in BCD and carry into the next field on wrap. Hours count 00 to 23.
- R3: At the 23:59:59 rollover the date wraps to 01 after its last day. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months. February ends on 28, or on 29 in a leap year.
- R4: A year is a leap year when its two-digit value is divisible by 4, and year 00 counts as a leap year. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R5: The day of week counts 1 to 7, advances together with the date, and wraps from 7 to 1.
- R6: The window is the top eight addresses (base = 2^ADDR_W − 8). The offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Any other address reads 0x00, and writes to it have no effect.
- R7: When control bits 7 and 6 are both clear, the time shadows take the new counter value in the cycle of each one-second advance. A host write to a time byte changes only its shadow, and the next advance overwrites it. If a host write and a refresh fall in the same cycle, the refresh wins.
- R8: While control bit 6 is set, the shadow refresh is suspended and the counters keep running. After the bit is cleared, the next advance shows the current time.
- R9: While control bit 7 is set, the refresh stops and the counters and the prescaler hold. A control write that clears bit 7 loads the counters from the shadows and restarts the prescaler. The first advance after the load therefore comes TICKS_PER_SEC ticks later.
- R10: Control bits 5:0 (bit 5 sign, bits 4:0 magnitude) read back as written and have no effect on counting.
- R11: After reset the control byte reads 0x00 and the time reads 00:00:00. The day of week, date and month read 01, and the year reads 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle strobe at the timebase rate |
| host_cs | input | 1 | Host access select |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from the shadows |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4 and ADDR_W kept at 13. With that setting each simulated second costs four tick strobes. Minute, hour, month-end, February and year rollovers can then be reached in a few dozen cycles by loading a time just before the boundary. The 13-bit address keeps the window at 1FF8h to 1FFFh, so the bench also drives addresses just below the window.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam rtc_time_t RTC_TIME_RST = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                           day: 8'h01, hour: 8'h00, min: 8'h00,
                                           sec: 8'h00};

    localparam int unsigned OFF_CTRL  = 0;
    localparam int unsigned OFF_SEC   = 1;
    localparam int unsigned OFF_MIN   = 2;
    localparam int unsigned OFF_HOUR  = 3;
    localparam int unsigned OFF_DAY   = 4;
    localparam int unsigned OFF_DATE  = 5;
    localparam int unsigned OFF_MONTH = 6;
    localparam int unsigned OFF_YEAR  = 7;

    localparam int unsigned CTRL_LOAD_BIT = 7;
    localparam int unsigned CTRL_SNAP_BIT = 6;

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
        return b + 8'd1;
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] month,
                                                  input logic [7:0] year);
        logic [7:0] yr_bin;
        logic       leap;
        yr_bin = ({4'd0, year[7:4]} * 8'd10) + {4'd0, year[3:0]};
        leap   = (yr_bin[1:0] == 2'b00);
        case (month)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic hold,
    input  logic restart,
    output logic sec_pulse
);
    localparam int unsigned CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (restart) begin
            cnt_d = '0;
        end else if (!hold && tick_en) begin
            if (cnt_q == CNT_LAST) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    assign sec_pulse = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> (tick_en && !hold)); // R1
    AST_COUNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> (cnt_q == '0)); // R1
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !restart) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      advance,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t time_q,
    output rtc_time_t time_adv
);
    rtc_time_t time_d;
    logic      sec_wrap, min_wrap, hour_wrap, date_wrap, month_wrap;
    logic [7:0] last_day;

    always_comb begin
        time_adv   = time_q;
        last_day   = month_last_day(time_q.month, time_q.year);
        sec_wrap   = (time_q.sec >= 8'h59);
        min_wrap   = sec_wrap && (time_q.min >= 8'h59);
        hour_wrap  = min_wrap && (time_q.hour >= 8'h23);
        date_wrap  = hour_wrap && (time_q.date >= last_day);
        month_wrap = date_wrap && (time_q.month >= 8'h12);

        time_adv.sec = sec_wrap ? 8'h00 : bcd_inc(time_q.sec);
        if (sec_wrap)
            time_adv.min = (time_q.min >= 8'h59) ? 8'h00 : bcd_inc(time_q.min);
        if (min_wrap)
            time_adv.hour = (time_q.hour >= 8'h23) ? 8'h00 : bcd_inc(time_q.hour);
        if (hour_wrap) begin
            time_adv.day  = (time_q.day >= 8'h07) ? 8'h01 : bcd_inc(time_q.day);
            time_adv.date = (time_q.date >= last_day) ? 8'h01 : bcd_inc(time_q.date);
        end
        if (date_wrap)
            time_adv.month = (time_q.month >= 8'h12) ? 8'h01 : bcd_inc(time_q.month);
        if (month_wrap)
            time_adv.year = (time_q.year >= 8'h99) ? 8'h00 : bcd_inc(time_q.year);

        if (load)         time_d = load_val;
        else if (advance) time_d = time_adv;
        else              time_d = time_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= RTC_TIME_RST;
        else        time_q <= time_d;
    end

    AST_SEC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && time_q.sec == 8'h59) |=> (time_q.sec == 8'h00)); // R2
    AST_DOW_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && time_q.sec == 8'h59 && time_q.min == 8'h59 &&
         time_q.hour == 8'h23 && time_q.day == 8'h07) |=> (time_q.day == 8'h01)); // R5
    AST_YEAR_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && time_q.sec == 8'h59 && time_q.min == 8'h59 &&
         time_q.hour == 8'h23 && time_q.date == 8'h31 && time_q.month == 8'h12 &&
         time_q.year == 8'h99) |=> (time_q.year == 8'h00 && time_q.month == 8'h01)); // R4
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(time_q)); // R9

endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_off,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_off,
    output logic [7:0] rd_data,
    input  logic       refresh,
    input  rtc_time_t  refresh_val,
    output logic [7:0] ctrl_q,
    output rtc_time_t  shadow_time
);
    typedef struct packed {
        logic [7:0] ctrl;
        rtc_time_t  tm;
    } shadow_state_t;

    shadow_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            case (wr_off)
                3'(OFF_CTRL):  state_d.ctrl     = wr_data;
                3'(OFF_SEC):   state_d.tm.sec   = wr_data;
                3'(OFF_MIN):   state_d.tm.min   = wr_data;
                3'(OFF_HOUR):  state_d.tm.hour  = wr_data;
                3'(OFF_DAY):   state_d.tm.day   = wr_data;
                3'(OFF_DATE):  state_d.tm.date  = wr_data;
                3'(OFF_MONTH): state_d.tm.month = wr_data;
                default:       state_d.tm.year  = wr_data;
            endcase
        end
        if (refresh) state_d.tm = refresh_val;
    end

    always_comb begin
        case (rd_off)
            3'(OFF_CTRL):  rd_data = state_q.ctrl;
            3'(OFF_SEC):   rd_data = state_q.tm.sec;
            3'(OFF_MIN):   rd_data = state_q.tm.min;
            3'(OFF_HOUR):  rd_data = state_q.tm.hour;
            3'(OFF_DAY):   rd_data = state_q.tm.day;
            3'(OFF_DATE):  rd_data = state_q.tm.date;
            3'(OFF_MONTH): rd_data = state_q.tm.month;
            default:       rd_data = state_q.tm.year;
        endcase
    end

    assign ctrl_q      = state_q.ctrl;
    assign shadow_time = state_q.tm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctrl <= 8'h00;
            state_q.tm   <= RTC_TIME_RST;
        end else begin
            state_q <= state_d;
        end
    end

    AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ctrl[CTRL_SNAP_BIT] && !wr_en) |=> $stable(state_q.tm)); // R8
    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == 3'(OFF_CTRL)) |=> (state_q.ctrl == $past(wr_data))); // R10

endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 13,
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    localparam int unsigned OFF_W = 3;

    logic       in_window, wr_en, load, hold, sec_pulse, refresh;
    logic [2:0] off;
    logic [7:0] ctrl_q, shd_rdata;
    rtc_time_t  cal_time, cal_adv, shd_time;

    assign in_window = host_cs && (&host_addr[ADDR_W-1:OFF_W]);
    assign off       = host_addr[OFF_W-1:0];
    assign wr_en     = in_window && host_we;
    assign hold      = ctrl_q[CTRL_LOAD_BIT];
    assign load      = wr_en && (off == 3'(OFF_CTRL)) && hold && !host_wdata[CTRL_LOAD_BIT];
    assign refresh   = sec_pulse && !ctrl_q[CTRL_SNAP_BIT] && !hold;
    assign host_rdata = in_window ? shd_rdata : 8'h00;

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .hold      (hold),
        .restart   (load),
        .sec_pulse (sec_pulse)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (sec_pulse),
        .load     (load),
        .load_val (shd_time),
        .time_q   (cal_time),
        .time_adv (cal_adv)
    );

    rtc_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_off      (off),
        .wr_data     (host_wdata),
        .rd_off      (off),
        .rd_data     (shd_rdata),
        .refresh     (refresh),
        .refresh_val (cal_adv),
        .ctrl_q      (ctrl_q),
        .shadow_time (shd_time)
    );

    AST_LOAD_TAKES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cal_time == $past(shd_time))); // R9
    AST_REFRESH_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (shd_time == cal_time)); // R7
    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_window |-> (host_rdata == 8'h00)); // R6

endmodule

// File: tb/rtc_calendar_top_test.sv
module rtc_calendar_top_test;
    localparam int unsigned ADDR_W = 13;
    localparam int unsigned TPS    = 4;
    localparam logic [ADDR_W-1:0] BASE = 13'h1FF8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              host_cs = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    rtc_calendar_top #(.ADDR_W(ADDR_W), .TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .host_cs(host_cs),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b0; host_addr = a;
        #1 d = host_rdata;
        host_cs = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] hr, mn, sc, dy, dt, mo, yr);
        wr(BASE, 8'h80);
        wr(BASE + 1, sc); wr(BASE + 2, mn); wr(BASE + 3, hr);
        wr(BASE + 4, dy); wr(BASE + 5, dt); wr(BASE + 6, mo); wr(BASE + 7, yr);
        wr(BASE, 8'h00);
    endtask

    task automatic expect_time(input string req, input logic [7:0] hr, mn, sc, dy, dt, mo, yr);
        logic [7:0] v;
        rd(BASE + 1, v); check(req, "sec",   v, sc);
        rd(BASE + 2, v); check(req, "min",   v, mn);
        rd(BASE + 3, v); check(req, "hour",  v, hr);
        rd(BASE + 4, v); check(req, "day",   v, dy);
        rd(BASE + 5, v); check(req, "date",  v, dt);
        rd(BASE + 6, v); check(req, "month", v, mo);
        rd(BASE + 7, v); check(req, "year",  v, yr);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(BASE, v); check("R11", "ctrl", v, 8'h00);
        expect_time("R11", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    endtask

    task automatic t_outside;
        logic [7:0] v;
        wr(BASE - 1, 8'h55);
        rd(BASE - 1, v); check("R6", "below window", v, 8'h00);
        wr(13'h0000, 8'hA5);
        rd(13'h0000, v); check("R6", "address zero", v, 8'h00);
        rd(BASE + 1, v); check("R6", "sec untouched", v, 8'h00);
    endtask

    task automatic t_prescale;
        logic [7:0] v;
        ticks(3);
        repeat (5) @(negedge clk);
        rd(BASE + 1, v); check("R1", "3 ticks", v, 8'h00);
        ticks(1);
        rd(BASE + 1, v); check("R1", "4 ticks", v, 8'h01);
    endtask

    task automatic t_carries;
        set_time(8'h00, 8'h59, 8'h59, 8'h03, 8'h10, 8'h05, 8'h21);
        ticks(TPS);
        expect_time("R2", 8'h01, 8'h00, 8'h00, 8'h03, 8'h10, 8'h05, 8'h21);
        set_time(8'h12, 8'h34, 8'h59, 8'h03, 8'h10, 8'h05, 8'h21);
        ticks(TPS);
        expect_time("R2", 8'h12, 8'h35, 8'h00, 8'h03, 8'h10, 8'h05, 8'h21);
    endtask

    task automatic t_year_end;
        set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
        ticks(TPS);
        expect_time("R4_R5", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    endtask

    task automatic t_month_end;
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h04, 8'h23);
        ticks(TPS);
        expect_time("R3", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h23);
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h30, 8'h05, 8'h23);
        ticks(TPS);
        expect_time("R3", 8'h00, 8'h00, 8'h00, 8'h03, 8'h31, 8'h05, 8'h23);
        set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h28, 8'h02, 8'h23);
        ticks(TPS);
        expect_time("R3", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h23);
    endtask

    task automatic t_leap;
        set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h28, 8'h02, 8'h24);
        ticks(TPS);
        expect_time("R4", 8'h00, 8'h00, 8'h00, 8'h05, 8'h29, 8'h02, 8'h24);
        set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h29, 8'h02, 8'h24);
        ticks(TPS);
        expect_time("R4", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h03, 8'h24);
        set_time(8'h23, 8'h59, 8'h59, 8'h06, 8'h28, 8'h02, 8'h00);
        ticks(TPS);
        expect_time("R4", 8'h00, 8'h00, 8'h00, 8'h07, 8'h29, 8'h02, 8'h00);
    endtask

    task automatic t_snapshot;
        logic [7:0] v;
        set_time(8'h12, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h10);
        wr(BASE, 8'h40);
        ticks(2 * TPS);
        rd(BASE + 1, v); check("R8", "frozen snapshot", v, 8'h00);
        wr(BASE, 8'h00);
        rd(BASE + 1, v); check("R8", "stale until refresh", v, 8'h00);
        ticks(TPS);
        rd(BASE + 1, v); check("R8", "counters kept running", v, 8'h03);
    endtask

    task automatic t_load_freeze;
        logic [7:0] v;
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h10);
        wr(BASE, 8'h80);
        ticks(2 * TPS);
        wr(BASE, 8'h00);
        rd(BASE + 1, v); check("R9", "loaded sec", v, 8'h00);
        ticks(TPS - 1);
        rd(BASE + 1, v); check("R9", "prescaler restarted", v, 8'h00);
        ticks(1);
        expect_time("R9", 8'h10, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10);
    endtask

    task automatic t_shadow_write;
        logic [7:0] v;
        set_time(8'h08, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h10);
        ticks(TPS);
        wr(BASE + 1, 8'h45);
        rd(BASE + 1, v); check("R7", "shadow holds host byte", v, 8'h45);
        ticks(TPS);
        rd(BASE + 1, v); check("R7", "counter untouched", v, 8'h02);
    endtask

    task automatic t_calib;
        logic [7:0] v;
        set_time(8'h08, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h10);
        wr(BASE, 8'h3A);
        rd(BASE, v); check("R10", "calib readback", v, 8'h3A);
        ticks(TPS);
        rd(BASE + 1, v); check("R10", "normal rate", v, 8'h01);
        wr(BASE, 8'h25);
        rd(BASE, v); check("R10", "calib readback 2", v, 8'h25);
        ticks(TPS);
        rd(BASE + 1, v); check("R10", "normal rate 2", v, 8'h02);
        wr(BASE, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_outside();
        t_prescale();
        t_carries();
        t_year_end();
        t_month_end();
        t_leap();
        t_snapshot();
        t_load_freeze();
        t_shadow_write();
        t_calib();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule